// File: doc/BRIEF.md
# Serial flash identification reader

This block fetches and checks the identification bytes of a serial NOR flash. After one `start_i` pulse it asserts chip select, asks a byte-exchange port to send the read-ID command byte, and keeps clocking out filler bytes to collect the reply. Each continuation code (0x7F) in the reply moves a bank number one step up from 1. The next manufacturer byte must have odd parity. If it does, two device bytes follow and the results are copied into the identification outputs.

The byte-exchange port shifts the bits. The block raises `xfer_req_o` with the byte to send in `xfer_tx_o`. The port answers with a one-cycle `xfer_ack_i` that carries the byte it received on `xfer_rx_i`. If `xfer_req_o` is still high in the cycle after an acknowledge, that is a new byte request. A parity failure, or too many continuation codes, ends the run early with an error. The run then leaves the previous identification untouched.

Top module: `jedec_id_reader`

## Requirements
- R1: After reset, `cs_o`, `xfer_req_o`, `done_o` and `err_o` are 0, and `bank_o`, `manuf_o`, `dev_hi_o` and `dev_lo_o` are all 0.
- R2: A `start_i` seen while idle asserts `cs_o` in the following cycle. The first byte requested carries `READ_ID_OP` (default 0x9F). `cs_o` stays high without a gap until the cycle in which `done_o` is high, and `xfer_req_o` is only ever high while `cs_o` is high.
- R3: The bank number starts at 1 for each run. Every received byte equal to 0x7F in the manufacturer position adds 1 and causes another manufacturer byte to be requested. Every byte requested after the command byte is 0x00.
- R4: A manufacturer byte whose bits XOR to 0 (even parity) ends the run with `err_o`=1. No device byte is requested, so a run with k continuation codes makes exactly k+2 exchanges.
- R5: After an odd-parity manufacturer byte, exactly two further bytes are exchanged. The first goes to `dev_hi_o` and the second to `dev_lo_o`. A successful run with k continuation codes makes k+4 exchanges.
- R6: `bank_o`, `manuf_o`, `dev_hi_o` and `dev_lo_o` change only in a cycle where `done_o`=1 and `err_o`=0. A failed run leaves their earlier values in place.
- R7: Up to `MAX_CONT` (default 15) continuation codes are accepted, giving at most bank `MAX_CONT`+1. A further continuation code ends the run with `err_o`=1 after `MAX_CONT`+2 exchanges.
- R8: `done_o` is high for exactly one cycle per run, with `cs_o`=0 in that cycle on both the success and the error paths. `err_o` is only ever high together with `done_o`.
- R9: `start_i` has no effect while a run is in progress. The run makes the same number of exchanges and produces a single `done_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an identification run (ignored unless idle) |
| cs_o | output | 1 | Flash chip select, 1 = selected |
| xfer_req_o | output | 1 | Byte exchange request, held until acknowledged |
| xfer_tx_o | output | 8 | Byte to send for the pending exchange |
| xfer_ack_i | input | 1 | One-cycle completion of the pending exchange |
| xfer_rx_i | input | 8 | Byte received, valid with `xfer_ack_i` |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | Run failed, valid with `done_o` |
| bank_o | output | BANK_W (5) | Manufacturer bank number of the last good run |
| manuf_o | output | 8 | Manufacturer code of the last good run |
| dev_hi_o | output | 8 | First device byte of the last good run |
| dev_lo_o | output | 8 | Second device byte of the last good run |

## Verification
The reply streams vary the number of leading continuation codes: none, a few, exactly the cap, and one past the cap. Together these separate correct bank counting from an off-by-one in the counter or its limit. They are mixed with manufacturer bytes of odd and of even parity, so a failed run directly after a good one shows whether the outputs are held back. Counting the exchanges and logging the bytes sent in every run separates an early abort from a run that reads device bytes it should not. A second start issued in the middle of a run must not change that count.

// File: rtl/jedec_id_pkg.sv
package jedec_id_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_MANUF,
    ST_DEV_HI,
    ST_DEV_LO,
    ST_FINISH
  } rd_state_e;
endpackage

// File: rtl/jedec_parity.sv
module jedec_parity #(
  parameter int W = 8
) (
  input  logic [W-1:0] data_i,
  output logic         odd_o
);
  assign odd_o = ^data_i;
endmodule

// File: rtl/jedec_bank_cnt.sv
module jedec_bank_cnt #(
  parameter int MAX_CONT = 15,
  parameter int BANK_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [BANK_W-1:0] bank_o,
  output logic              full_o
);
  localparam logic [BANK_W-1:0] TopBank = BANK_W'(MAX_CONT + 1);

  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                bank_q <= BANK_W'(1);
    else if (clr_i)             bank_q <= BANK_W'(1);
    else if (inc_i && !full_o)  bank_q <= bank_q + BANK_W'(1);
  end

  assign full_o = (bank_q == TopBank);
  assign bank_o = bank_q;
endmodule

// File: rtl/jedec_id_reader.sv
module jedec_id_reader
  import jedec_id_pkg::*;
#(
  parameter logic [7:0] READ_ID_OP = 8'h9F,
  parameter logic [7:0] CONT_CODE  = 8'h7F,
  parameter int         MAX_CONT   = 15,
  localparam int        BANK_W     = $clog2(MAX_CONT + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              cs_o,
  output logic              xfer_req_o,
  output logic [7:0]        xfer_tx_o,
  input  logic              xfer_ack_i,
  input  logic [7:0]        xfer_rx_i,
  output logic              done_o,
  output logic              err_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [7:0]        manuf_o,
  output logic [7:0]        dev_hi_o,
  output logic [7:0]        dev_lo_o
);
  rd_state_e state_q, state_d;
  logic err_q, err_d;
  logic [7:0] manuf_wk_q, dev_hi_wk_q;
  logic [BANK_W-1:0] bank_cnt, bank_q;
  logic [7:0] manuf_q, dev_hi_q, dev_lo_q;
  logic cnt_full, rx_odd, rx_cont, cnt_clr, cnt_inc, commit;

  assign rx_cont = (xfer_rx_i == CONT_CODE);
  assign cnt_clr = (state_q == ST_IDLE) && start_i;
  assign cnt_inc = (state_q == ST_MANUF) && xfer_ack_i && rx_cont;
  assign commit  = (state_q == ST_DEV_LO) && xfer_ack_i;

  jedec_parity #(.W(8)) u_par (
    .data_i (xfer_rx_i),
    .odd_o  (rx_odd)
  );

  jedec_bank_cnt #(.MAX_CONT(MAX_CONT), .BANK_W(BANK_W)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .bank_o (bank_cnt),
    .full_o (cnt_full)
  );

  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_OPC;
        err_d   = 1'b0;
      end
      ST_OPC: if (xfer_ack_i) state_d = ST_MANUF;
      ST_MANUF: if (xfer_ack_i) begin
        if (rx_cont) begin
          // a continuation code past the cap aborts the run
          if (cnt_full) begin
            state_d = ST_FINISH;
            err_d   = 1'b1;
          end
        end else if (!rx_odd) begin
          state_d = ST_FINISH;
          err_d   = 1'b1;
        end else begin
          state_d = ST_DEV_HI;
        end
      end
      ST_DEV_HI: if (xfer_ack_i) state_d = ST_DEV_LO;
      ST_DEV_LO: if (xfer_ack_i) state_d = ST_FINISH;
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  // working copies, only published when the whole run succeeds
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      manuf_wk_q  <= '0;
      dev_hi_wk_q <= '0;
    end else begin
      if (state_q == ST_MANUF && xfer_ack_i)  manuf_wk_q  <= xfer_rx_i;
      if (state_q == ST_DEV_HI && xfer_ack_i) dev_hi_wk_q <= xfer_rx_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q   <= '0;
      manuf_q  <= '0;
      dev_hi_q <= '0;
      dev_lo_q <= '0;
    end else if (commit) begin
      bank_q   <= bank_cnt;
      manuf_q  <= manuf_wk_q;
      dev_hi_q <= dev_hi_wk_q;
      dev_lo_q <= xfer_rx_i;
    end
  end

  assign cs_o       = (state_q == ST_OPC) || (state_q == ST_MANUF) ||
                      (state_q == ST_DEV_HI) || (state_q == ST_DEV_LO);
  assign xfer_req_o = cs_o;
  assign xfer_tx_o  = (state_q == ST_OPC) ? READ_ID_OP : 8'h00;
  assign done_o     = (state_q == ST_FINISH);
  assign err_o      = done_o && err_q;
  assign bank_o     = bank_q;
  assign manuf_o    = manuf_q;
  assign dev_hi_o   = dev_hi_q;
  assign dev_lo_o   = dev_lo_q;
endmodule

// File: rtl/jedec_id_chk.sv
module jedec_id_chk #(
  parameter int BANK_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_o,
  input logic              xfer_req_o,
  input logic              done_o,
  input logic              err_o,
  input logic [BANK_W-1:0] bank_o,
  input logic [7:0]        manuf_o,
  input logic [7:0]        dev_hi_o,
  input logic [7:0]        dev_lo_o
);
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_err_with_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  p_cs_free_at_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cs_o);
  p_req_in_frame_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o |-> cs_o);
  p_cs_drop_at_end_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_o) |-> done_o);
  p_manuf_commit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(manuf_o) |-> (done_o && !err_o));
  p_bank_commit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bank_o) |-> (done_o && !err_o));
  p_dev_commit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(dev_hi_o) || !$stable(dev_lo_o)) |-> (done_o && !err_o));
  p_bank_nonzero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (bank_o != '0));
endmodule

bind jedec_id_reader jedec_id_chk #(.BANK_W(BANK_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_o       (cs_o),
  .xfer_req_o (xfer_req_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .bank_o     (bank_o),
  .manuf_o    (manuf_o),
  .dev_hi_o   (dev_hi_o),
  .dev_lo_o   (dev_lo_o)
);

// File: tb/sim_jedec_id_reader.sv
`timescale 1ns/1ps
module sim_jedec_id_reader;
  localparam int MAX_CONT = 15;
  localparam int BANK_W   = 5;
  localparam int NVEC     = 8;
  // {k continuation codes, manufacturer, device hi, device lo}
  localparam logic [28:0] VEC [NVEC] = '{
    {5'd0,  8'hEF, 8'h40, 8'h18},
    {5'd2,  8'h1F, 8'h86, 8'h01},
    {5'd0,  8'h03, 8'h11, 8'h22},
    {5'd1,  8'hC2, 8'h20, 8'h17},
    {5'd3,  8'h00, 8'h33, 8'h44},
    {5'd15, 8'h01, 8'h5A, 8'hA5},
    {5'd16, 8'h01, 8'h66, 8'h77},
    {5'd7,  8'h9D, 8'hAA, 8'h55}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic xfer_ack_i = 1'b0;
  logic [7:0] xfer_rx_i = 8'h00;
  logic cs_o, xfer_req_o, done_o, err_o;
  logic [7:0] xfer_tx_o, manuf_o, dev_hi_o, dev_lo_o;
  logic [BANK_W-1:0] bank_o;

  jedec_id_reader u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .cs_o(cs_o), .xfer_req_o(xfer_req_o), .xfer_tx_o(xfer_tx_o),
    .xfer_ack_i(xfer_ack_i), .xfer_rx_i(xfer_rx_i),
    .done_o(done_o), .err_o(err_o), .bank_o(bank_o),
    .manuf_o(manuf_o), .dev_hi_o(dev_hi_o), .dev_lo_o(dev_lo_o)
  );

  always #2.5 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  int n_xfer = 0;
  int n_done = 0;
  logic [7:0] rx_seq [64];
  logic [7:0] tx_log [64];

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // byte-exchange responder: two-cycle latency, one-cycle acknowledge
  initial begin
    forever begin
      @(negedge clk);
      xfer_ack_i = 1'b0;
      if (xfer_req_o) begin
        repeat (2) @(negedge clk);
        tx_log[n_xfer] = xfer_tx_o;
        xfer_rx_i = rx_seq[n_xfer];
        n_xfer++;
        xfer_ack_i = 1'b1;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (done_o) n_done++;
    end
  end

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL R8 watchdog act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic load(int k, logic [7:0] m, logic [7:0] d0, logic [7:0] d1);
    for (int i = 0; i < 64; i++) rx_seq[i] = 8'h00;
    rx_seq[0] = 8'hA5;
    for (int i = 0; i < k; i++) rx_seq[1+i] = 8'h7F;
    rx_seq[1+k] = m;
    rx_seq[2+k] = d0;
    rx_seq[3+k] = d1;
  endtask

  task automatic begin_run();
    n_xfer = 0;
    n_done = 0;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 cs one cycle after start", int'(cs_o), 1);
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done_o && t < 3000) begin
      @(negedge clk);
      t++;
    end
    if (!done_o) chk("R8 done timeout", 0, 1);
  endtask

  int e_bank = 0, e_man = 0, e_hi = 0, e_lo = 0;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cs", int'(cs_o), 0);
    chk("R1 req", int'(xfer_req_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 err", int'(err_o), 0);
    chk("R1 ids", int'({bank_o, manuf_o, dev_hi_o, dev_lo_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      int k, exp_err, exp_x, bad_tx;
      logic [7:0] m, d0, d1;
      k  = int'(VEC[v][28:24]);
      m  = VEC[v][23:16];
      d0 = VEC[v][15:8];
      d1 = VEC[v][7:0];
      load(k, m, d0, d1);
      exp_err = (k > MAX_CONT) || (^m == 1'b0);
      exp_x   = (k > MAX_CONT) ? MAX_CONT + 2 : ((^m == 1'b0) ? k + 2 : k + 4);
      if (!exp_err) begin
        e_bank = k + 1; e_man = int'(m); e_hi = int'(d0); e_lo = int'(d1);
      end
      begin_run();
      wait_done();
      chk((k > MAX_CONT) ? "R7 err past cap" : "R4 err on parity", int'(err_o), exp_err);
      chk("R3 bank", int'(bank_o), e_bank);
      chk("R6 manuf", int'(manuf_o), e_man);
      chk("R5 dev hi", int'(dev_hi_o), e_hi);
      chk("R5 dev lo", int'(dev_lo_o), e_lo);
      chk("R8 cs released at done", int'(cs_o), 0);
      chk("R2 opcode byte", int'(tx_log[0]), 8'h9F);
      bad_tx = 0;
      for (int i = 1; i < n_xfer; i++) if (tx_log[i] != 8'h00) bad_tx++;
      chk("R3 filler bytes", bad_tx, 0);
      @(negedge clk);
      chk(exp_err ? "R4 exchange count" : "R5 exchange count", n_xfer, exp_x);
      chk("R8 single done", n_done, 1);
      chk("R8 done falls", int'(done_o), 0);
    end

    // R9: second start mid-run is ignored
    load(2, 8'h1F, 8'h12, 8'h34);
    begin_run();
    repeat (6) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    repeat (20) @(negedge clk);
    chk("R9 exchange count", n_xfer, 6);
    chk("R9 done count", n_done, 1);
    chk("R9 idle cs", int'(cs_o), 0);
    chk("R9 dev lo", int'(dev_lo_o), 8'h34);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule